// File: doc/BRIEF.md
# Multiply-Accumulate Datapath

This block is the multiply-accumulate datapath of a general-purpose DSP core. An external control unit drives its strobes. Two 16-bit operand registers, X and Y, load through select muxes. X takes either the data-memory bus or the low half of the result-bus feedback, so an earlier arithmetic result can be reused as an operand. Y takes either the data-memory bus or the program-memory bus. On a machine with one shared memory bus, the control unit loads the two operands in separate cycles, and the datapath itself is unchanged.

The signed product of X and Y is either added into a 40-bit result or written straight into the low result register, skipping the adder. The 40-bit result lives in two registers: a 32-bit low word and an 8-bit high byte.

A read strobe places the result on the 32-bit result bus. A narrow read takes one cycle and carries the low word. A wide read adds a second cycle. In that cycle the high byte goes out on bus bits 7:0, and bits 31:8 carry its sign extension.

Top module: `mac_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) zeroes both operand registers, both result registers and the readout, so rbus_out is 0 and rbus_valid is 0.
- R2: When x_load is 1, X loads from dm_data if x_src_rbus is 0, and from rbus_in[15:0] if x_src_rbus is 1. When y_load is 1, Y loads from dm_data if y_src_pm is 0, and from pm_data if y_src_pm is 1.
- R3: Operand registers change only at an edge where their load strobe is 1. Result registers change only at an edge where mac_en is 1. The product used at an edge comes from the operand values held before that edge.
- R4: The product is the signed two's complement product of X and Y. For example, 0xFFFD times 0x0007 gives 0xFFFFFFEB, and 0x8000 times 0x8000 gives 0x40000000.
- R5: Accumulate mode is mac_en=1, mul_only=0, acc_clear=0. In this mode the 40-bit result {high, low} becomes its old value plus the product sign-extended to 40 bits.
- R6: Multiply-only mode is mac_en=1, mul_only=1. The low register takes the product and the high byte keeps its value. mul_only takes priority over acc_clear.
- R7: Clear mode is mac_en=1, mul_only=0, acc_clear=1. In this mode the 40-bit result becomes the sign-extended product, and the old value is discarded.
- R8: A narrow read is rd_start=1 with rd_wide=0, sampled at an edge. During the following cycle rbus_valid is 1 and rbus_out holds the low word. The read lasts exactly one cycle.
- R9: A wide read is rd_start=1 with rd_wide=1. Its first cycle matches R8. In the next cycle rbus_valid is 1, rbus_out[7:0] carries the high byte, and rbus_out[31:8] carries copies of that byte's bit 7.
- R10: The 40-bit sum wraps modulo 2^40 without saturating. 512 additions of 0x40000000 give high byte 0x80 and low word 0. 1024 additions give 0.
- R11: A rd_start sampled at the edge that begins the second cycle of a wide read is ignored.
- R12: A read returns the result held just before the edge at which rd_start is sampled, including the high byte of a wide read. This holds even if mac_en changes the result at that same edge or one cycle later.
- R13: In every cycle that is not a read cycle, rbus_valid is 0 and rbus_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dm_data | input | 16 | Data-memory data bus |
| pm_data | input | 16 | Program-memory data bus |
| rbus_in | input | 32 | Result-bus feedback; X takes bits 15:0 |
| x_src_rbus | input | 1 | X source: 0 data memory, 1 result bus |
| x_load | input | 1 | Load strobe for X |
| y_src_pm | input | 1 | Y source: 0 data memory, 1 program memory |
| y_load | input | 1 | Load strobe for Y |
| mac_en | input | 1 | Update the result registers this edge |
| mul_only | input | 1 | Multiply-only: product into low word, high byte held |
| acc_clear | input | 1 | Clear mode: result replaced by product |
| rd_start | input | 1 | Start a readout |
| rd_wide | input | 1 | Readout covers all 40 bits (two cycles) |
| rbus_out | output | 32 | Result bus drive |
| rbus_valid | output | 1 | Marks each readout cycle |

## Verification
The hardest case to reach from the ports is the 40-bit wrap. It needs the high byte to cross its sign bit and then roll over to zero. Even the largest product, (-32768)², needs 512 additions before the high byte reaches 0x80. The stimulus therefore clears the result with that product and then streams 1023 back-to-back accumulates, with a wide read at the halfway point and another at the end. A second hard case comes from the timing rules. A read is made in the same cycle as an accumulate, and a new read strobe is issued during the second cycle of a wide read. Together these show that the bus reports the value held when the read was sampled, and that the stray strobe is dropped.

// File: rtl/mac_pkg.sv
// Package: shared types for the multiply-accumulate datapath.
// Assumes: nothing beyond standard SystemVerilog packed types.
package mac_pkg;

    // Result-register update controls, grouped so they travel together.
    typedef struct packed {
        logic en;
        logic mul_only;
        logic clear;
    } acc_ctrl_t;

    // Readout sequencer state: idle/first word, or second word still owed.
    typedef enum logic {
        RO_FREE     = 1'b0,
        RO_HIGH_DUE = 1'b1
    } ro_state_t;

endpackage

// File: rtl/mac_operand_regs.sv
// Module: mac_operand_regs
// Holds the X and Y operands. Each has a two-way source mux and a load strobe.
// Assumes: OP_W <= BUS_W. X takes the low OP_W bits of the result-bus feedback.
module mac_operand_regs #(
    parameter int OP_W  = 16,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  dm_data,
    input  logic [OP_W-1:0]  pm_data,
    input  logic [BUS_W-1:0] rbus_in,
    input  logic             x_src_rbus,
    input  logic             x_load,
    input  logic             y_src_pm,
    input  logic             y_load,
    output logic [OP_W-1:0]  x_q,
    output logic [OP_W-1:0]  y_q
);

    logic [OP_W-1:0] x_next;
    logic [OP_W-1:0] y_next;

    // Source selection for both operand registers.
    always_comb begin
        x_next = x_src_rbus ? rbus_in[OP_W-1:0] : dm_data;
        y_next = y_src_pm   ? pm_data           : dm_data;
    end

    // Operand registers: load only when strobed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            if (x_load) x_q <= x_next;
            if (y_load) y_q <= y_next;
        end
    end

endmodule

// File: rtl/mac_arith.sv
// Module: mac_arith
// Signed multiplier and 40-bit accumulator. The result is kept as a low word
// and a high guard byte. In multiply-only mode the product skips the adder.
// Assumes: 2*OP_W <= BUS_W < ACC_W. Sums wrap; there is no saturation.
module mac_arith
    import mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40,
    parameter int BUS_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [OP_W-1:0]        x_q,
    input  logic [OP_W-1:0]        y_q,
    input  acc_ctrl_t              ctrl,
    output logic [BUS_W-1:0]       acc_lo,
    output logic [ACC_W-BUS_W-1:0] acc_hi
);

    localparam int PROD_W = 2 * OP_W;
    localparam int HI_W   = ACC_W - BUS_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] product;
    logic [ACC_W-1:0]         prod_ext;
    logic [BUS_W-1:0]         prod_lo;
    logic [ACC_W-1:0]         acc_sum;

    // Signed multiply, then sign extension to the accumulator width.
    always_comb begin
        product  = $signed(x_q) * $signed(y_q);
        prod_ext = {{EXT_W{product[PROD_W-1]}}, product};
        acc_sum  = {acc_hi, acc_lo} + prod_ext;
    end

    // Bypass path into the low word; its width depends on the parameters.
    generate
        if (BUS_W > PROD_W) begin : g_lo_ext
            assign prod_lo = {{(BUS_W-PROD_W){product[PROD_W-1]}}, product};
        end else begin : g_lo_fit
            assign prod_lo = product;
        end
    endgenerate

    // Result registers: multiply-only, clear-and-load, or accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_lo <= '0;
            acc_hi <= '0;
        end else if (ctrl.en) begin
            if (ctrl.mul_only) begin
                acc_lo <= prod_lo;
            end else if (ctrl.clear) begin
                acc_lo <= prod_ext[BUS_W-1:0];
                acc_hi <= prod_ext[ACC_W-1:BUS_W];
            end else begin
                acc_lo <= acc_sum[BUS_W-1:0];
                acc_hi <= acc_sum[ACC_W-1:BUS_W];
            end
        end
    end

    // HI_W is used for documentation of the split; tie it to the port width.
    logic [HI_W-1:0] unused_hi_shape;
    assign unused_hi_shape = acc_hi;

endmodule

// File: rtl/mac_readout.sv
// Module: mac_readout
// Drives the result onto the shared bus: the low word in one cycle, plus an
// optional second cycle carrying the sign-extended high byte in the low lane.
// Assumes: HI_W < BUS_W. The high byte is captured when the read starts.
module mac_readout
    import mac_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int HI_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] acc_lo,
    input  logic [HI_W-1:0]  acc_hi,
    input  logic             rd_start,
    input  logic             rd_wide,
    output logic [BUS_W-1:0] rbus_out,
    output logic             rbus_valid
);

    localparam int UP_W = BUS_W - HI_W;

    ro_state_t       state;
    logic [HI_W-1:0] hi_snap;
    logic [BUS_W-1:0] hi_word;

    // Upper lane is the sign of the high byte, lower lane the byte itself.
    always_comb begin
        hi_word = {{UP_W{hi_snap[HI_W-1]}}, hi_snap};
    end

    // Readout sequencer and registered bus drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RO_FREE;
            hi_snap    <= '0;
            rbus_out   <= '0;
            rbus_valid <= 1'b0;
        end else if (state == RO_HIGH_DUE) begin
            rbus_out   <= hi_word;
            rbus_valid <= 1'b1;
            state      <= RO_FREE;
        end else if (rd_start) begin
            rbus_out   <= acc_lo;
            rbus_valid <= 1'b1;
            hi_snap    <= acc_hi;
            state      <= rd_wide ? RO_HIGH_DUE : RO_FREE;
        end else begin
            rbus_out   <= '0;
            rbus_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/mac_unit.sv
// Module: mac_unit (top)
// Multiply-accumulate datapath: operand muxes and registers, signed multiply,
// 40-bit accumulate or multiply-only bypass, and result-bus readout.
// Assumes: all strobes come from an external control unit, registered on clk.
module mac_unit
    import mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  dm_data,
    input  logic [OP_W-1:0]  pm_data,
    input  logic [BUS_W-1:0] rbus_in,
    input  logic             x_src_rbus,
    input  logic             x_load,
    input  logic             y_src_pm,
    input  logic             y_load,
    input  logic             mac_en,
    input  logic             mul_only,
    input  logic             acc_clear,
    input  logic             rd_start,
    input  logic             rd_wide,
    output logic [BUS_W-1:0] rbus_out,
    output logic             rbus_valid
);

    localparam int HI_W = ACC_W - BUS_W;

    logic [OP_W-1:0]  x_q;
    logic [OP_W-1:0]  y_q;
    logic [BUS_W-1:0] acc_lo;
    logic [HI_W-1:0]  acc_hi;
    acc_ctrl_t        acc_ctrl;

    // Bundle the mode strobes for the arithmetic stage.
    always_comb begin
        acc_ctrl.en       = mac_en;
        acc_ctrl.mul_only = mul_only;
        acc_ctrl.clear    = acc_clear;
    end

    mac_operand_regs #(.OP_W(OP_W), .BUS_W(BUS_W)) u_ops (
        .clk        (clk),
        .rst_n      (rst_n),
        .dm_data    (dm_data),
        .pm_data    (pm_data),
        .rbus_in    (rbus_in),
        .x_src_rbus (x_src_rbus),
        .x_load     (x_load),
        .y_src_pm   (y_src_pm),
        .y_load     (y_load),
        .x_q        (x_q),
        .y_q        (y_q)
    );

    mac_arith #(.OP_W(OP_W), .ACC_W(ACC_W), .BUS_W(BUS_W)) u_arith (
        .clk    (clk),
        .rst_n  (rst_n),
        .x_q    (x_q),
        .y_q    (y_q),
        .ctrl   (acc_ctrl),
        .acc_lo (acc_lo),
        .acc_hi (acc_hi)
    );

    mac_readout #(.BUS_W(BUS_W), .HI_W(HI_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_lo     (acc_lo),
        .acc_hi     (acc_hi),
        .rd_start   (rd_start),
        .rd_wide    (rd_wide),
        .rbus_out   (rbus_out),
        .rbus_valid (rbus_valid)
    );

endmodule

// File: rtl/mac_unit_chk.sv
// Module: mac_unit_chk
// Checker for mac_unit, attached by bind. It keeps its own readout shadow
// state and checks register holds, the readout words and the idle bus.
// Assumes: synchronous active-low reset; all properties are disabled in reset.
module mac_unit_chk #(
    parameter int OP_W  = 16,
    parameter int BUS_W = 32,
    parameter int HI_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             x_load,
    input logic             y_load,
    input logic             mac_en,
    input logic             mul_only,
    input logic             rd_start,
    input logic             rd_wide,
    input logic [BUS_W-1:0] rbus_out,
    input logic             rbus_valid,
    input logic [OP_W-1:0]  x_q,
    input logic [OP_W-1:0]  y_q,
    input logic [BUS_W-1:0] acc_lo,
    input logic [HI_W-1:0]  acc_hi
);

    logic pend_c;

    // Shadow flag: the low word of a wide read is on the bus now.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_c <= 1'b0;
        else        pend_c <= rd_start && rd_wide && !pend_c;
    end

    AST_X_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !x_load |=> $stable(x_q)); // R3
    AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !y_load |=> $stable(y_q)); // R3
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_en |=> ($stable(acc_lo) && $stable(acc_hi))); // R3
    AST_MULONLY_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && mul_only) |=> $stable(acc_hi)); // R6
    AST_LOW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !pend_c) |=> (rbus_valid && rbus_out == $past(acc_lo))); // R8
    AST_HIGH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        pend_c |=> (rbus_valid && rbus_out[HI_W-1:0] == $past(acc_hi, 2)
                    && rbus_out[BUS_W-1:HI_W] == {(BUS_W-HI_W){rbus_out[HI_W-1]}})); // R9
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rbus_valid |-> (rbus_out == '0)); // R13

endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W), .BUS_W(BUS_W), .HI_W(ACC_W-BUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .x_load     (x_load),
    .y_load     (y_load),
    .mac_en     (mac_en),
    .mul_only   (mul_only),
    .rd_start   (rd_start),
    .rd_wide    (rd_wide),
    .rbus_out   (rbus_out),
    .rbus_valid (rbus_valid),
    .x_q        (x_q),
    .y_q        (y_q),
    .acc_lo     (acc_lo),
    .acc_hi     (acc_hi)
);

// File: tb/mac_unit_tb.sv
// Bench for mac_unit: a behavioural reference model steps on every rising
// edge, and the bus outputs are compared against it at every falling edge.
module mac_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] dm_data, pm_data;
    logic [31:0] rbus_in;
    logic        x_src_rbus, x_load, y_src_pm, y_load;
    logic        mac_en, mul_only, acc_clear, rd_start, rd_wide;
    logic [31:0] rbus_out;
    logic        rbus_valid;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    model_live = 0;
    bit    done = 0;

    // Reference state
    logic [15:0] x_m, y_m;
    logic [31:0] lo_m;
    logic [7:0]  hi_m, snap_m;
    logic [31:0] out_m;
    logic        val_m;
    bit          busy_m;
    longint      p_m;
    logic [39:0] wide_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_unit u_dut (
        .clk(clk), .rst_n(rst_n), .dm_data(dm_data), .pm_data(pm_data),
        .rbus_in(rbus_in), .x_src_rbus(x_src_rbus), .x_load(x_load),
        .y_src_pm(y_src_pm), .y_load(y_load), .mac_en(mac_en),
        .mul_only(mul_only), .acc_clear(acc_clear), .rd_start(rd_start),
        .rd_wide(rd_wide), .rbus_out(rbus_out), .rbus_valid(rbus_valid)
    );

    // Reference model: one step per rising edge, from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            x_m = 0; y_m = 0; lo_m = 0; hi_m = 0; snap_m = 0;
            out_m = 0; val_m = 0; busy_m = 0;
            model_live = 1;
        end else begin
            p_m = longint'($signed(x_m)) * longint'($signed(y_m));
            if (busy_m) begin
                out_m = {{24{snap_m[7]}}, snap_m}; val_m = 1; busy_m = 0;
            end else if (rd_start) begin
                out_m = lo_m; val_m = 1; busy_m = rd_wide; snap_m = hi_m;
            end else begin
                out_m = 0; val_m = 0;
            end
            if (mac_en) begin
                if (mul_only) lo_m = 32'(p_m);
                else begin
                    wide_m = acc_clear ? 40'(p_m) : ({hi_m, lo_m} + 40'(p_m));
                    hi_m = wide_m[39:32]; lo_m = wide_m[31:0];
                end
            end
            if (x_load) x_m = x_src_rbus ? rbus_in[15:0] : dm_data;
            if (y_load) y_m = y_src_pm ? pm_data : dm_data;
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (model_live && !done) begin
            n_checks++;
            if (rbus_valid !== val_m || rbus_out !== out_m) begin
                n_fail++;
                $display("FAIL %s: bus actual valid=%0b data=%h expected valid=%0b data=%h",
                         cur_req, rbus_valid, rbus_out, val_m, out_m);
            end
        end
    end

    task automatic drive(input logic xl, xs, yl, ys, me, mo, ac, rs, rw,
                         input logic [15:0] dm, pm, input logic [31:0] rb);
        @(negedge clk); #1;
        x_load = xl; x_src_rbus = xs; y_load = yl; y_src_pm = ys;
        mac_en = me; mul_only = mo; acc_clear = ac; rd_start = rs; rd_wide = rw;
        dm_data = dm; pm_data = pm; rbus_in = rb;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0,0,0,0,0,0,0,0,0, 16'h5A5A, 16'hA5A5, 32'h1234_5678);
    endtask

    // Load X from data memory and Y from program memory in one cycle.
    task automatic load_xy(input logic [15:0] xv, yv);
        drive(1,0,1,1,0,0,0,0,0, xv, yv, 32'h0);
    endtask

    task automatic do_mac(input logic mo, ac);
        drive(0,0,0,0,1,mo,ac,0,0, 16'h0, 16'h0, 32'h0);
    endtask

    task automatic do_read(input logic wide);
        drive(0,0,0,0,0,0,0,1,wide, 16'h0, 16'h0, 32'h0);
        idle(2);
    endtask

    task automatic finish_run;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual run still active expected finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 0;
        {x_load, x_src_rbus, y_load, y_src_pm, mac_en, mul_only, acc_clear, rd_start, rd_wide} = '0;
        dm_data = 16'hFFFF; pm_data = 16'hFFFF; rbus_in = '1;
        idle(3);
        rst_n = 1;
        cur_req = "R1"; do_read(1);                                  // R1 zeros after reset

        cur_req = "R2"; load_xy(16'd3, 16'd5); do_mac(1, 0); do_read(0);
        drive(1,1,1,0,0,0,0,0,0, 16'd9, 16'd77, 32'hABCD_0007);       // R2 X from rbus_in, Y from dm
        do_mac(1, 0); do_read(0);

        cur_req = "R3";                                               // R3 no load, no mac
        drive(0,0,0,0,0,0,0,0,0, 16'd100, 16'd100, 32'h0000_0064);
        do_read(0); do_mac(1, 0); do_read(0);
        drive(1,0,0,0,1,1,0,0,0, 16'd2, 16'd0, 32'h0);               // R3 mac uses old X
        do_read(0); do_mac(1, 0); do_read(0);

        cur_req = "R4"; load_xy(16'hFFFD, 16'h0007); do_mac(1, 0); do_read(1);
        load_xy(16'h8000, 16'h8000); do_mac(1, 0); do_read(1);

        cur_req = "R7"; load_xy(16'hFF00, 16'h0100); do_mac(0, 1); do_read(1);

        cur_req = "R5"; load_xy(16'd100, 16'hFF38);
        do_mac(0, 0); do_mac(0, 0); do_mac(0, 0); do_read(1);

        cur_req = "R6"; load_xy(16'd2, 16'd3); do_mac(1, 0); do_read(1);
        load_xy(16'd7, 16'd7); drive(0,0,0,0,1,1,1,0,0, 0, 0, 0); do_read(1); // R6 priority

        cur_req = "R8";                                               // R8 back-to-back narrow
        drive(0,0,0,0,0,0,0,1,0, 0, 0, 0); drive(0,0,0,0,0,0,0,1,0, 0, 0, 0); idle(2);

        cur_req = "R12"; load_xy(16'h4000, 16'h4000); do_mac(0, 1);
        drive(0,0,0,0,1,0,0,1,1, 0, 0, 0);                            // R12 read + mac same edge
        do_mac(0, 0); idle(2); do_read(1);

        cur_req = "R11"; drive(0,0,0,0,0,0,0,1,1, 0, 0, 0);
        drive(0,0,0,0,0,0,0,1,0, 0, 0, 0); idle(3);                   // R11 stray strobe dropped

        cur_req = "R10"; load_xy(16'h8000, 16'h8000); do_mac(0, 1);
        for (int i = 0; i < 511; i++) do_mac(0, 0);
        do_read(1);                                                   // R10 hi=0x80
        for (int i = 0; i < 512; i++) do_mac(0, 0);
        do_read(1);                                                   // R10 wrapped to 0

        cur_req = "R13"; idle(4);                                     // R13 idle bus
        cur_req = "R1"; rst_n = 0; idle(2); rst_n = 1; do_read(1);    // R1 reset again
        finish_run();
    end

endmodule